// File: doc/BRIEF.md
# Event-driven state-machine timer

This block is a configurable counter/timer whose actions come from a small programmable state machine rather than fixed wiring from compare values to pins. A current-state register, compare results from five match/capture registers and four input pins are combined into six events. Each event can set, clear or toggle any of four outputs, capture the counter, load a new state, and act as a counter limit.

The counter is 32 bits wide, or it runs as two independent 16-bit halves. Each half counts either up only or up/down. A limit event returns an up-only counter to zero. It turns an up/down counter around. Counting advances only while the shared count-enable input is high and the run bit of that counter (or half) is set. All settings are loaded through a one-cycle write port, and every write takes effect at the clock edge that samples it.

Top module: `evt_state_timer`

## Requirements
- R1: After the asynchronous active-low reset releases, `countVal`, `stateVal`, `outPins`, `evtFired` and every register value on `regVal` are zero.
- R2: The mode word (address 0x00) has these bits: 0 split, 1 up/down for the low or whole counter, 2 up/down for the high half, 3 run for the low or whole counter, 4 run for the high half. With split clear, run set and `countEn` high, the 32-bit counter rises by one per clock. With `countEn` low it holds.
- R3: In up-only mode a firing event whose limit-low flag is set makes the counter 0 at the next edge. This takes effect only on a counting cycle. A match register (value address 0x18+k) matches when it is not in capture mode and equals the counter.
- R4: In up/down mode a limit event reverses the direction: from up at value v the next value is v-1. Counting down from 1 gives 0 and resumes counting up, so a limit at 3 yields 0,1,2,3,2,1,0,1,2.
- R5: With split set, bits 15:0 and 31:16 count independently. Each half has its own run bit, up/down bit and limit flag (limit-high is event bit 18), and a half that is not running ignores its limit. A register with control bit 1 set (control address 0x20+k) compares its low 16 bits against the high half. Otherwise it compares against the low half.
- R6: The event word (address 0x08+e) holds these fields: [7:0] state mask, [10:8] match select, [12:11] input select, [14:13] condition, [16:15] mode (0 off, 1 match, 2 input, 3 both ANDed), bit 17 limit-low, bit 18 limit-high, bit 19 load state, [22:20] new state. An event fires only while the state-mask bit indexed by the current state is set. `evtFired` shows the events firing in the present cycle.
- R7: Input conditions are 0 high, 1 low, 2 rise and 3 fall. Rise and fall compare the present pin value against its value at the previous clock edge.
- R8: A firing event with load-state set writes its new state at the next edge. When several do so in one cycle, the highest-numbered event wins. A write to address 0x01 sets the state directly.
- R9: The output word (address 0x10+o) holds a set mask in [5:0] and a clear mask in [13:8]. At the next edge an output becomes 1 on set only, 0 on clear only, and inverts when both are present. Without either it holds.
- R10: A register with control bit 0 set is in capture mode, and its capture event is control bits [4:2]. When that event fires, the register loads the counter value of that same cycle, taken before any limit reset. A capture-mode register never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countEn | input | 1 | Count enable shared by both halves |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration address |
| cfgData | input | 32 | Configuration write data |
| inPins | input | 4 | Event input pins |
| outPins | output | 4 | Event-driven outputs |
| stateVal | output | 3 | Current state |
| evtFired | output | 6 | Events firing this cycle |
| countVal | output | 32 | Counter value (high half in 31:16 when split) |
| regVal | output | 160 | Match/capture register k in bits 32k+31:32k |

## Verification
Two pairs of functions can land in the same cycle. A limit reset can coincide with a capture, and a set can coincide with a clear of the same output. The capture case is provoked by making one compare event both the limit and the capture trigger. It is judged by the captured value, which must equal the compare value and not zero, while the counter reads zero one edge later. The output case is provoked by driving the two event inputs together, and it is judged by both a set/clear output and a self-cleared output inverting.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  parameter int CNT_W  = 32;
  parameter int EVT_N  = 6;
  parameter int REG_N  = 5;
  parameter int ST_N   = 8;
  parameter int IN_N   = 4;
  parameter int OUT_N  = 4;
  localparam int HALF_W = CNT_W / 2;
  localparam int ST_W   = $clog2(ST_N);
  localparam int SEL_W  = 3;
  localparam int SEL_N  = 1 << SEL_W;
  localparam int IN_W   = $clog2(IN_N);

  localparam logic [7:0] ADDR_MODE  = 8'h00;
  localparam logic [7:0] ADDR_STATE = 8'h01;
  localparam logic [7:0] ADDR_EVT   = 8'h08;
  localparam logic [7:0] ADDR_OUT   = 8'h10;
  localparam logic [7:0] ADDR_VAL   = 8'h18;
  localparam logic [7:0] ADDR_RCTL  = 8'h20;

  typedef enum logic [1:0] {COND_HIGH, COND_LOW, COND_RISE, COND_FALL} inCond_e;
  typedef enum logic [1:0] {EV_OFF, EV_MATCH, EV_INPUT, EV_BOTH} evMode_e;

  typedef struct packed {
    logic split;
    logic bidirLo;
    logic bidirHi;
    logic runLo;
    logic runHi;
  } modeCfg_t;

  typedef struct packed {
    logic [ST_N-1:0]  stateMask;
    logic [SEL_W-1:0] matchSel;
    logic [IN_W-1:0]  inSel;
    inCond_e          inCond;
    evMode_e          mode;
    logic             limitLo;
    logic             limitHi;
    logic             loadState;
    logic [ST_W-1:0]  newState;
  } evtCfg_t;

  typedef struct packed {
    logic [EVT_N-1:0] fired;
    logic             limitLo;
    logic             limitHi;
    logic [REG_N-1:0] capStb;
  } ctlStrobe_t;

  function automatic evtCfg_t decodeEvt(input logic [31:0] d);
    evtCfg_t c;
    c.stateMask = d[7:0];
    c.matchSel  = d[10:8];
    c.inSel     = d[12:11];
    c.inCond    = inCond_e'(d[14:13]);
    c.mode      = evMode_e'(d[16:15]);
    c.limitLo   = d[17];
    c.limitHi   = d[18];
    c.loadState = d[19];
    c.newState  = d[22:20];
    return c;
  endfunction
endpackage

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
  import evtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgAddr,
  input  logic [31:0]      cfgData,
  input  logic [IN_N-1:0]  inPins,
  input  modeCfg_t         modeCfg,
  input  logic [REG_N-1:0] eqFull,
  input  logic [REG_N-1:0] eqLo,
  input  logic [REG_N-1:0] eqHi,
  output ctlStrobe_t       strobe,
  output logic [ST_W-1:0]  stateVal,
  output logic [OUT_N-1:0] outPins
);
  evtCfg_t          evtCfg [EVT_N];
  logic [EVT_N-1:0] setMask [OUT_N];
  logic [EVT_N-1:0] clrMask [OUT_N];
  logic [REG_N-1:0] isCap;
  logic [REG_N-1:0] useHigh;
  logic [SEL_W-1:0] capEvt [REG_N];
  logic [IN_N-1:0]  inPrev;
  logic [ST_W-1:0]  curState, nextState;
  logic [OUT_N-1:0] outReg, nextOut;
  logic [REG_N-1:0] matchHit;
  logic [SEL_N-1:0] matchPad;
  logic [EVT_N-1:0] fired;
  logic [SEL_N-1:0] firedPad;
  logic [EVT_N-1:0] limLoVec, limHiVec;

  // Compare results qualified by register role and counter layout
  always_comb begin
    for (int k = 0; k < REG_N; k++) begin
      if (isCap[k])           matchHit[k] = 1'b0;
      else if (!modeCfg.split) matchHit[k] = eqFull[k];
      else                     matchHit[k] = useHigh[k] ? eqHi[k] : eqLo[k];
    end
    matchPad = '0;
    matchPad[REG_N-1:0] = matchHit;
  end

  // Per-event configuration storage and evaluation
  for (genvar e = 0; e < EVT_N; e++) begin : g_evt
    logic stOk, mHit, iHit, inNow, inOld;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        evtCfg[e] <= '0;
      else if (cfgWrEn && cfgAddr == 8'(ADDR_EVT + e))
        evtCfg[e] <= decodeEvt(cfgData);
    end
    always_comb begin
      stOk  = evtCfg[e].stateMask[curState];
      mHit  = matchPad[evtCfg[e].matchSel];
      inNow = inPins[evtCfg[e].inSel];
      inOld = inPrev[evtCfg[e].inSel];
      unique case (evtCfg[e].inCond)
        COND_HIGH: iHit = inNow;
        COND_LOW:  iHit = !inNow;
        COND_RISE: iHit = inNow && !inOld;
        default:   iHit = !inNow && inOld;
      endcase
      unique case (evtCfg[e].mode)
        EV_OFF:   fired[e] = 1'b0;
        EV_MATCH: fired[e] = stOk && mHit;
        EV_INPUT: fired[e] = stOk && iHit;
        default:  fired[e] = stOk && mHit && iHit;
      endcase
      limLoVec[e] = evtCfg[e].limitLo;
      limHiVec[e] = evtCfg[e].limitHi;
    end
  end

  // Output mask storage
  for (genvar o = 0; o < OUT_N; o++) begin : g_outCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        setMask[o] <= '0;
        clrMask[o] <= '0;
      end else if (cfgWrEn && cfgAddr == 8'(ADDR_OUT + o)) begin
        setMask[o] <= cfgData[EVT_N-1:0];
        clrMask[o] <= cfgData[8 +: EVT_N];
      end
    end
  end

  // Match/capture register roles
  for (genvar k = 0; k < REG_N; k++) begin : g_regCtl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        isCap[k]   <= 1'b0;
        useHigh[k] <= 1'b0;
        capEvt[k]  <= '0;
      end else if (cfgWrEn && cfgAddr == 8'(ADDR_RCTL + k)) begin
        isCap[k]   <= cfgData[0];
        useHigh[k] <= cfgData[1];
        capEvt[k]  <= cfgData[2 +: SEL_W];
      end
    end
  end

  // State transition: later (higher) events override earlier ones
  always_comb begin
    nextState = curState;
    for (int e = 0; e < EVT_N; e++)
      if (fired[e] && evtCfg[e].loadState) nextState = evtCfg[e].newState;
    if (cfgWrEn && cfgAddr == ADDR_STATE) nextState = cfgData[ST_W-1:0];
  end

  // Output update with toggle on simultaneous set and clear
  always_comb begin
    for (int o = 0; o < OUT_N; o++) begin
      unique case ({|(setMask[o] & fired), |(clrMask[o] & fired)})
        2'b11:   nextOut[o] = !outReg[o];
        2'b10:   nextOut[o] = 1'b1;
        2'b01:   nextOut[o] = 1'b0;
        default: nextOut[o] = outReg[o];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= '0;
      outReg   <= '0;
      inPrev   <= '0;
    end else begin
      curState <= nextState;
      outReg   <= nextOut;
      inPrev   <= inPins;
    end
  end

  // Strobes towards the datapath
  always_comb begin
    firedPad = '0;
    firedPad[EVT_N-1:0] = fired;
    strobe.fired   = fired;
    strobe.limitLo = |(fired & limLoVec);
    strobe.limitHi = |(fired & limHiVec);
    for (int k = 0; k < REG_N; k++)
      strobe.capStb[k] = isCap[k] && firedPad[capEvt[k]];
  end

  assign stateVal = curState;
  assign outPins  = outReg;
endmodule

// File: rtl/evtmr_dpath.sv
module evtmr_dpath
  import evtmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   countEn,
  input  logic                   cfgWrEn,
  input  logic [7:0]             cfgAddr,
  input  logic [31:0]            cfgData,
  input  ctlStrobe_t             strobe,
  output modeCfg_t               modeCfg,
  output logic [CNT_W-1:0]       countVal,
  output logic [REG_N*CNT_W-1:0] regVal,
  output logic [REG_N-1:0]       eqFull,
  output logic [REG_N-1:0]       eqLo,
  output logic [REG_N-1:0]       eqHi
);
  typedef struct packed {
    logic             up;
    logic [CNT_W-1:0] val;
  } stepRes_t;

  logic [CNT_W-1:0] cnt, nextCnt;
  logic             dirLo, dirHi, nextDirLo, nextDirHi;
  logic [CNT_W-1:0] regs [REG_N];
  stepRes_t         rLo, rHi;

  function automatic stepRes_t stepCount(input logic [CNT_W-1:0] v, input logic bidir,
                                         input logic up, input logic limit);
    stepRes_t r;
    r.up  = up;
    r.val = v;
    if (!bidir) begin
      r.up  = 1'b1;
      r.val = limit ? '0 : v + 1'b1;
    end else if (up) begin
      if (limit && v != '0) begin
        r.up  = 1'b0;
        r.val = v - 1'b1;
      end else begin
        r.val = v + 1'b1;
      end
    end else if (limit || v == '0) begin
      r.up  = 1'b1;
      r.val = v + 1'b1;
    end else begin
      r.val = v - 1'b1;
      if (v == CNT_W'(1)) r.up = 1'b1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      modeCfg <= '0;
    else if (cfgWrEn && cfgAddr == ADDR_MODE) begin
      modeCfg.split   <= cfgData[0];
      modeCfg.bidirLo <= cfgData[1];
      modeCfg.bidirHi <= cfgData[2];
      modeCfg.runLo   <= cfgData[3];
      modeCfg.runHi   <= cfgData[4];
    end
  end

  always_comb begin
    nextCnt   = cnt;
    nextDirLo = dirLo;
    nextDirHi = dirHi;
    rLo = stepCount(modeCfg.split ? {{HALF_W{1'b0}}, cnt[HALF_W-1:0]} : cnt,
                    modeCfg.bidirLo, dirLo, strobe.limitLo);
    rHi = stepCount({{HALF_W{1'b0}}, cnt[CNT_W-1:HALF_W]},
                    modeCfg.bidirHi, dirHi, strobe.limitHi);
    if (countEn && modeCfg.runLo) begin
      nextDirLo = rLo.up;
      if (modeCfg.split) nextCnt[HALF_W-1:0] = rLo.val[HALF_W-1:0];
      else               nextCnt = rLo.val;
    end
    if (countEn && modeCfg.split && modeCfg.runHi) begin
      nextDirHi = rHi.up;
      nextCnt[CNT_W-1:HALF_W] = rHi.val[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dirLo <= 1'b1;
      dirHi <= 1'b1;
    end else begin
      cnt   <= nextCnt;
      dirLo <= nextDirLo;
      dirHi <= nextDirHi;
    end
  end

  // Match/capture values: a configuration write takes priority over a capture
  for (genvar k = 0; k < REG_N; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[k] <= '0;
      else if (cfgWrEn && cfgAddr == 8'(ADDR_VAL + k))
        regs[k] <= cfgData[CNT_W-1:0];
      else if (strobe.capStb[k])
        regs[k] <= cnt;
    end
    assign eqFull[k] = (regs[k] == cnt);
    assign eqLo[k]   = (regs[k][HALF_W-1:0] == cnt[HALF_W-1:0]);
    assign eqHi[k]   = (regs[k][HALF_W-1:0] == cnt[CNT_W-1:HALF_W]);
    assign regVal[k*CNT_W +: CNT_W] = regs[k];
  end

  assign countVal = cnt;
endmodule

// File: rtl/evt_state_timer.sv
module evt_state_timer
  import evtmr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   countEn,
  input  logic                   cfgWrEn,
  input  logic [7:0]             cfgAddr,
  input  logic [31:0]            cfgData,
  input  logic [IN_N-1:0]        inPins,
  output logic [OUT_N-1:0]       outPins,
  output logic [ST_W-1:0]        stateVal,
  output logic [EVT_N-1:0]       evtFired,
  output logic [CNT_W-1:0]       countVal,
  output logic [REG_N*CNT_W-1:0] regVal
);
  modeCfg_t         modeCfg;
  ctlStrobe_t       strobe;
  logic [REG_N-1:0] eqFull, eqLo, eqHi;

  evtmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inPins(inPins), .modeCfg(modeCfg), .eqFull(eqFull), .eqLo(eqLo), .eqHi(eqHi),
    .strobe(strobe), .stateVal(stateVal), .outPins(outPins)
  );

  evtmr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .countEn(countEn), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .strobe(strobe), .modeCfg(modeCfg), .countVal(countVal),
    .regVal(regVal), .eqFull(eqFull), .eqLo(eqLo), .eqHi(eqHi)
  );

  assign evtFired = strobe.fired;
endmodule

// File: rtl/evtmr_checker.sv
module evtmr_checker
  import evtmr_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   countEn,
  input logic                   cfgWrEn,
  input ctlStrobe_t             strobe,
  input modeCfg_t               modeCfg,
  input logic [CNT_W-1:0]       countVal,
  input logic [ST_W-1:0]        stateVal,
  input logic [OUT_N-1:0]       outPins,
  input logic [REG_N*CNT_W-1:0] regVal
);
  // R2: no enable, no write -> counter holds
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !cfgWrEn) |=> $stable(countVal));

  // R2: whole up-only counter advances by one
  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !cfgWrEn && !modeCfg.split && modeCfg.runLo && !modeCfg.bidirLo && !strobe.limitLo)
    |=> countVal == $past(countVal) + 1'b1);

  // R3: limit in up-only mode clears the counter
  assert_limit_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !cfgWrEn && !modeCfg.split && modeCfg.runLo && !modeCfg.bidirLo && strobe.limitLo)
    |=> countVal == '0);

  // R8: without events or writes the state holds
  assert_state_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!(|strobe.fired) && !cfgWrEn) |=> $stable(stateVal));

  // R9: outputs move only on events
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(|strobe.fired) |=> $stable(outPins));

  // R10: a capture loads the counter value of the strobe cycle
  for (genvar k = 0; k < REG_N; k++) begin : g_cap
    assert_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capStb[k] && !cfgWrEn) |=> regVal[k*CNT_W +: CNT_W] == $past(countVal));
  end
endmodule

bind evt_state_timer evtmr_checker u_chk (
  .clk(clk), .rstN(rstN), .countEn(countEn), .cfgWrEn(cfgWrEn), .strobe(strobe),
  .modeCfg(modeCfg), .countVal(countVal), .stateVal(stateVal), .outPins(outPins),
  .regVal(regVal)
);

// File: tb/evt_state_timer_bench.sv
module evt_state_timer_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         countEn = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [7:0]   cfgAddr = '0;
  logic [31:0]  cfgData = '0;
  logic [3:0]   inPins = '0;
  logic [3:0]   outPins;
  logic [2:0]   stateVal;
  logic [5:0]   evtFired;
  logic [31:0]  countVal;
  logic [159:0] regVal;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  evt_state_timer u_evt_state_timer (
    .clk(clk), .rstN(rstN), .countEn(countEn), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .inPins(inPins), .outPins(outPins), .stateVal(stateVal),
    .evtFired(evtFired), .countVal(countVal), .regVal(regVal)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [31:0] evtWord(input int mask, input int msel, input int isel,
      input int cond, input int mode, input int limLo, input int limHi, input int ld, input int ns);
    return 32'(mask) | 32'(msel) << 8 | 32'(isel) << 11 | 32'(cond) << 13 | 32'(mode) << 15 |
           32'(limLo) << 17 | 32'(limHi) << 18 | 32'(ld) << 19 | 32'(ns) << 20;
  endfunction

  task automatic doReset();
    countEn = 1'b0; cfgWrEn = 1'b0; inPins = '0;
    @(negedge clk); rstN = 1'b0;
    step(2); rstN = 1'b1;
    step(1);
  endtask

  task automatic testReset_r1();
    doReset();
    check("R1 count", countVal, 0);
    check("R1 state", 32'(stateVal), 0);
    check("R1 outputs", 32'(outPins), 0);
    check("R1 events", 32'(evtFired), 0);
    for (int k = 0; k < 5; k++) check("R1 register", regVal[k*32 +: 32], 0);
  endtask

  task automatic testCount_r2();
    doReset();
    wr(8'h00, 32'h08);
    countEn = 1'b1; step(5);
    check("R2 up count", countVal, 5);
    countEn = 1'b0; step(3);
    check("R2 hold without enable", countVal, 5);
  endtask

  task automatic testLimit_r3();
    doReset();
    wr(8'h18, 4);
    wr(8'h08, evtWord(8'h01, 0, 0, 0, 1, 1, 0, 0, 0));
    wr(8'h00, 32'h08);
    countEn = 1'b1; step(4);
    check("R3 reach match", countVal, 4);
    check("R3 match event", 32'(evtFired[0]), 1);
    step(1);
    check("R3 limit reset", countVal, 0);
    step(2);
    check("R3 recount", countVal, 2);
  endtask

  task automatic testBidir_r4();
    doReset();
    wr(8'h18, 3);
    wr(8'h08, evtWord(8'h01, 0, 0, 0, 1, 1, 0, 0, 0));
    wr(8'h00, 32'h0A);
    countEn = 1'b1; step(4);
    check("R4 reversed", countVal, 2);
    step(2);
    check("R4 bottom", countVal, 0);
    step(2);
    check("R4 up again", countVal, 2);
  endtask

  task automatic testSplit_r5();
    doReset();
    wr(8'h19, 2);
    wr(8'h21, 32'h2);
    wr(8'h09, evtWord(8'h01, 1, 0, 0, 1, 0, 1, 0, 0));
    wr(8'h00, 32'h19);
    countEn = 1'b1; step(3);
    check("R5 high limit", countVal, 32'h0000_0003);
    step(2);
    check("R5 halves independent", countVal, 32'h0002_0005);
    countEn = 1'b0;
    wr(8'h00, 32'h09);
    countEn = 1'b1; step(2);
    check("R5 high half stopped", countVal, 32'h0002_0007);
  endtask

  task automatic testQualify_r6();
    doReset();
    wr(8'h08, evtWord(8'h02, 7, 0, 0, 2, 0, 0, 0, 0));
    wr(8'h10, 32'h01);
    inPins = 4'b0001;
    step(1);
    check("R6 state gate blocks", 32'(evtFired[0]), 0);
    step(1);
    check("R6 output untouched", 32'(outPins[0]), 0);
    wr(8'h01, 1);
    check("R6 state gate passes", 32'(evtFired[0]), 1);
    step(1);
    check("R6 output set", 32'(outPins[0]), 1);
    wr(8'h09, evtWord(8'hFF, 0, 1, 0, 3, 0, 0, 0, 0));
    check("R6 both missing input", 32'(evtFired[1]), 0);
    inPins = 4'b0011;
    step(1);
    check("R6 both satisfied", 32'(evtFired[1]), 1);
    wr(8'h18, 9);
    check("R6 both missing match", 32'(evtFired[1]), 0);
  endtask

  task automatic testInput_r7();
    doReset();
    wr(8'h08, evtWord(8'hFF, 7, 2, 2, 2, 0, 0, 0, 0));
    wr(8'h09, evtWord(8'hFF, 7, 2, 3, 2, 0, 0, 0, 0));
    wr(8'h0A, evtWord(8'hFF, 7, 3, 1, 2, 0, 0, 0, 0));
    check("R7 low level", 32'(evtFired), 32'h04);
    inPins = 4'b0100;
    #1 check("R7 rise", 32'(evtFired[1:0]), 1);
    step(1);
    check("R7 rise once", 32'(evtFired[1:0]), 0);
    inPins = 4'b1000;
    #1 check("R7 fall and not low", 32'(evtFired), 32'h02);
    step(1);
    check("R7 fall once", 32'(evtFired), 0);
  endtask

  task automatic testState_r8();
    doReset();
    wr(8'h08, evtWord(8'hFF, 7, 0, 0, 2, 0, 0, 1, 3));
    wr(8'h0B, evtWord(8'h01, 7, 0, 0, 2, 0, 0, 1, 5));
    inPins = 4'b0001;
    step(1);
    check("R8 highest event wins", 32'(stateVal), 5);
    step(1);
    check("R8 single load", 32'(stateVal), 3);
    step(1);
    check("R8 reload same", 32'(stateVal), 3);
  endtask

  task automatic testOutputs_r9();
    doReset();
    wr(8'h08, evtWord(8'hFF, 7, 0, 0, 2, 0, 0, 0, 0));
    wr(8'h09, evtWord(8'hFF, 7, 1, 0, 2, 0, 0, 0, 0));
    wr(8'h10, 32'h0201);
    wr(8'h12, 32'h0101);
    inPins = 4'b0001; step(1);
    check("R9 set", 32'(outPins), 32'h5);
    inPins = 4'b0010; step(1);
    check("R9 clear", 32'(outPins), 32'h4);
    inPins = 4'b0011; step(1);
    check("R9 toggle", 32'(outPins), 32'h1);
    inPins = 4'b0000; step(1);
    check("R9 hold", 32'(outPins), 32'h1);
  endtask

  task automatic testCapture_r10();
    doReset();
    wr(8'h18, 5);
    wr(8'h08, evtWord(8'hFF, 0, 0, 0, 1, 1, 0, 0, 0));
    wr(8'h1A, 3);
    wr(8'h22, 32'h1);
    wr(8'h09, evtWord(8'hFF, 2, 0, 0, 1, 0, 0, 0, 0));
    wr(8'h00, 32'h08);
    countEn = 1'b1; step(3);
    check("R10 count at capture value", countVal, 3);
    check("R10 capture reg no match", 32'(evtFired[1]), 0);
    step(2);
    check("R10 trigger cycle", 32'(evtFired[0]), 1);
    step(1);
    check("R10 captured pre-reset value", regVal[2*32 +: 32], 5);
    check("R10 counter reset same cycle", countVal, 0);
  endtask

  initial begin
    testReset_r1();
    testCount_r2();
    testLimit_r3();
    testBidir_r4();
    testSplit_r5();
    testQualify_r6();
    testInput_r7();
    testState_r8();
    testOutputs_r9();
    testCapture_r10();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule